// File: doc/BRIEF.md
# Feedforward-Feedback Duty Ratio Controller

This block computes the duty command for a two-switch AC chopper once per switching period. Each period it takes one instantaneous sample of the input voltage, the output voltage and the wanted output voltage, all signed Q1.15. A feedforward path divides the wanted output by the input to cancel input swings and harmonics sample by sample. A proportional-integral path acts on the output error and removes the steady-state offset. The sum of the nominal ratio, the feedforward correction and the PI correction is clamped into the unit range and handed to an external PWM timer as an unsigned Q0.16 value.

Samples arrive on a valid/ready port. A sample is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` then stays low until the result for that sample has been produced. A sample offered while `s_ready` is low is not taken and leaves no trace. The result port has no back-pressure. `d_valid` is a one-cycle pulse, and the consumer must capture `d_duty` then. `d_duty` keeps its value until the next pulse.

The division is a multi-cycle restoring divider, so one update takes at most `SW+DF+3` cycles. That is far inside a 25 µs switching period at any practical clock rate. An input magnitude below a programmable threshold skips the division.

Top module: `ffd_duty_ctrl`

## Requirements
- R1: A sample is taken only when `s_valid` and `s_ready` are both high at a clock edge. `s_ready` is low in the cycle after acceptance and stays low until the result is produced. Samples offered while `s_ready` is low produce no result and do not alter any later result.
- R2: Each accepted sample yields exactly one `d_valid` pulse of one cycle, no later than `SW+DF+3` cycles after acceptance. `d_duty` changes only in a cycle where `d_valid` is high.
- R3: When the input magnitude |vin| is nonzero and not below `cfg_thr`, the ratio magnitude is floor(|vref|·2^16/|vin|), limited to `RMAX_INT`·2^16. The ratio is negative when exactly one of vin and vref has its sign bit set. The feedforward correction is that ratio minus `cfg_df` (Q0.16).
- R4: When |vin| is zero or below `cfg_thr`, the division is skipped and the ratio is taken as +`RMAX_INT`·2^16, regardless of signs.
- R5: The proportional term is floor(kp·e / 2^13), with e = vref − vout in Q1.15 and kp (`cfg_kp`) signed Q2.14. The result is in Q.16 units.
- R6: For each accepted sample, a candidate integrator value m+e is formed and saturated to a signed `IW`-bit range. The integral term is floor(ki·candidate / 2^13), with ki (`cfg_ki`) signed Q2.14.
- R7: The sum is D = Df + (ratio − Df) + P + I. D below 0 gives `d_duty` = 0. D at or above 2^16 gives `d_duty` = 0xFFFF. Any other D is output as is.
- R8: The candidate integrator value is stored unless D is at or above 2^16 with e > 0, or D is below 0 with e < 0. In those two cases the integrator keeps its old value.
- R9: A synchronous reset clears the integrator. During reset, and after it, `d_duty` is 0, `d_valid` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample offer |
| s_ready | output | 1 | Block can take a sample |
| s_vin | input | SW | Input voltage sample, signed Q1.15 |
| s_vref | input | SW | Wanted output sample, signed Q1.15 |
| s_vout | input | SW | Measured output sample, signed Q1.15 |
| cfg_df | input | DF | Nominal steady-state ratio, unsigned Q0.16 |
| cfg_kp | input | GW | Proportional gain, signed Q2.14 |
| cfg_ki | input | GW | Integral gain, signed Q2.14 |
| cfg_thr | input | SW | Input magnitude below which division is skipped |
| d_valid | output | 1 | One-cycle result pulse |
| d_duty | output | DF | Duty command, unsigned Q0.16 |

## Verification
The bench builds the block with `IW` = 18 and every other parameter at its default. With this width, three samples carrying the largest error drive the integrator into its saturation limit. A small later integral gain then makes the saturated value visible at the duty output. The 33-step divider path and the skipped-division path are both exercised. Between them they cover results that fall inside the range and results that clamp at each end. The integrator freeze is made visible by applying a reverse error after several clamped samples.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_CALC = 2'd2
  } ffd_state_e;
endpackage

// File: rtl/ffd_rdiv.sv
// Restoring divider: one quotient bit per cycle, MSB first.
module ffd_rdiv #(
  parameter int NW = 33,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] den_q;
  logic [DW-1:0] rem_q;
  logic [NW-1:0] dvd_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [DW:0]   trial;
  logic          take;

  assign trial = {rem_q, dvd_q[NW-1]};
  assign take  = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      den_q <= '0;
      rem_q <= '0;
      dvd_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        den_q <= den;
        dvd_q <= num;
        rem_q <= '0;
        quot  <= '0;
        cnt_q <= CW'(NW - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= take ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
        dvd_q <= dvd_q << 1;
        quot  <= {quot[NW-2:0], take};
        if (cnt_q == '0) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ffd_pi.sv
// Proportional and integral terms with a saturating, freezable integrator.
module ffd_pi #(
  parameter int EW   = 17,
  parameter int GW   = 16,
  parameter int IW   = 24,
  parameter int PSH  = 13,
  parameter int ACCW = 44
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [EW-1:0]   err,
  input  logic signed [GW-1:0]   kp,
  input  logic signed [GW-1:0]   ki,
  input  logic                   commit,
  input  logic                   hold,
  output logic signed [ACCW-1:0] p_term,
  output logic signed [ACCW-1:0] i_term,
  output logic signed [IW-1:0]   m_q
);
  localparam logic signed [IW:0] M_MAX = (IW+1)'((64'sd1 <<< (IW - 1)) - 1);
  localparam logic signed [IW:0] M_MIN = -(IW+1)'(64'sd1 <<< (IW - 1));

  logic signed [IW:0]       m_sum;
  logic signed [IW-1:0]     m_cand;
  logic signed [GW+EW-1:0]  p_prod;
  logic signed [GW+IW-1:0]  i_prod;

  always_comb begin
    m_sum = (IW+1)'(m_q) + (IW+1)'(err);
    if (m_sum > M_MAX)      m_cand = M_MAX[IW-1:0];
    else if (m_sum < M_MIN) m_cand = M_MIN[IW-1:0];
    else                    m_cand = m_sum[IW-1:0];
  end

  assign p_prod = kp * err;
  assign i_prod = ki * m_cand;
  assign p_term = ACCW'(p_prod) >>> PSH;
  assign i_term = ACCW'(i_prod) >>> PSH;

  always_ff @(posedge clk) begin
    if (rst)                 m_q <= '0;
    else if (commit && !hold) m_q <= m_cand;
  end
endmodule

// File: rtl/ffd_duty_ctrl.sv
module ffd_duty_ctrl
  import ffd_pkg::*;
#(
  parameter int SW       = 16,
  parameter int GW       = 16,
  parameter int GF       = 14,
  parameter int DF       = 16,
  parameter int IW       = 24,
  parameter int RMAX_INT = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [SW-1:0] s_vin,
  input  logic signed [SW-1:0] s_vref,
  input  logic signed [SW-1:0] s_vout,
  input  logic [DF-1:0]        cfg_df,
  input  logic signed [GW-1:0] cfg_kp,
  input  logic signed [GW-1:0] cfg_ki,
  input  logic [SW-1:0]        cfg_thr,
  output logic                 d_valid,
  output logic [DF-1:0]        d_duty
);
  localparam int SF   = SW - 1;
  localparam int MW   = SW + 1;
  localparam int NW   = MW + DF;
  localparam int EW   = SW + 1;
  localparam int PSH  = GF + SF - DF;
  localparam int ACCW = GW + IW + 4;
  localparam logic [NW-1:0] RMAX_Q = NW'(RMAX_INT) << DF;
  localparam logic signed [ACCW-1:0] DMAX = ACCW'((64'sd1 <<< DF) - 1);

  ffd_state_e state_q;

  logic signed [SW-1:0] vref_q, vout_q;
  logic                 neg_q, byp_q;
  logic signed [MW-1:0] vin_x, vref_x;
  logic [MW-1:0]        vin_mag, vref_mag;
  logic                 accept, byp_now;
  logic                 div_done;
  logic [NW-1:0]        div_quot;
  logic [NW-1:0]        q_lim, ratio_mag;
  logic signed [ACCW-1:0] ratio_s, df_x, dh, sum, p_term, i_term;
  logic signed [EW-1:0] err;
  logic                 calc_en, clamp_hi, clamp_lo, err_pos, err_neg, hold;
  logic signed [IW-1:0] m_q;
  logic [DF-1:0]        duty_n;

  assign s_ready = (state_q == ST_IDLE);
  assign accept  = s_valid && s_ready;
  assign calc_en = (state_q == ST_CALC);

  assign vin_x    = {s_vin[SW-1], s_vin};
  assign vref_x   = {s_vref[SW-1], s_vref};
  assign vin_mag  = vin_x[MW-1]  ? MW'(-vin_x)  : MW'(vin_x);
  assign vref_mag = vref_x[MW-1] ? MW'(-vref_x) : MW'(vref_x);
  assign byp_now  = (vin_mag == '0) || (vin_mag < {1'b0, cfg_thr});

  ffd_rdiv #(.NW(NW), .DW(MW)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (accept && !byp_now),
    .num   ({vref_mag, {DF{1'b0}}}),
    .den   (vin_mag),
    .done  (div_done),
    .quot  (div_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vref_q  <= '0;
      vout_q  <= '0;
      neg_q   <= 1'b0;
      byp_q   <= 1'b0;
      d_valid <= 1'b0;
      d_duty  <= '0;
    end else begin
      d_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          vref_q  <= s_vref;
          vout_q  <= s_vout;
          neg_q   <= s_vin[SW-1] ^ s_vref[SW-1];
          byp_q   <= byp_now;
          state_q <= byp_now ? ST_CALC : ST_DIV;
        end
        ST_DIV: if (div_done) state_q <= ST_CALC;
        ST_CALC: begin
          d_duty  <= duty_n;
          d_valid <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Feedforward ratio and its correction against the nominal ratio.
  assign q_lim     = (div_quot > RMAX_Q) ? RMAX_Q : div_quot;
  assign ratio_mag = byp_q ? RMAX_Q : q_lim;
  assign ratio_s   = (neg_q && !byp_q) ? -ACCW'(ratio_mag) : ACCW'(ratio_mag);
  assign df_x      = ACCW'(cfg_df);
  assign dh        = ratio_s - df_x;

  // Feedback.
  assign err     = EW'(vref_q) - EW'(vout_q);
  assign err_pos = !err[EW-1] && (err != '0);
  assign err_neg = err[EW-1];

  ffd_pi #(.EW(EW), .GW(GW), .IW(IW), .PSH(PSH), .ACCW(ACCW)) u_pi (
    .clk    (clk),
    .rst    (rst),
    .err    (err),
    .kp     (cfg_kp),
    .ki     (cfg_ki),
    .commit (calc_en),
    .hold   (hold),
    .p_term (p_term),
    .i_term (i_term),
    .m_q    (m_q)
  );

  // Summation, clamp and anti-windup decision.
  assign sum      = df_x + dh + p_term + i_term;
  assign clamp_lo = sum[ACCW-1];
  assign clamp_hi = !clamp_lo && (sum > DMAX);
  assign hold     = (clamp_hi && err_pos) || (clamp_lo && err_neg);

  always_comb begin
    if (clamp_lo)      duty_n = '0;
    else if (clamp_hi) duty_n = '1;
    else               duty_n = sum[DF-1:0];
  end
endmodule

// File: rtl/ffd_duty_ctrl_chk.sv
module ffd_duty_ctrl_chk #(
  parameter int DF      = 16,
  parameter int IW      = 24,
  parameter int LAT_MAX = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic          d_valid,
  input logic [DF-1:0] d_duty,
  input logic          calc_en,
  input logic          clamp_hi,
  input logic          clamp_lo,
  input logic          err_pos,
  input logic          err_neg,
  input logic [IW-1:0] m_q
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || s_ready) busy_cnt <= '0;
    else                busy_cnt <= busy_cnt + 1'b1;
  end

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!d_valid && d_duty == '0 && s_ready));

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    d_valid |=> !d_valid);

  p_duty_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !d_valid |-> $stable(d_duty));

  p_latency_bound_r2: assert property (@(posedge clk) disable iff (rst)
    !s_ready |-> (busy_cnt < 16'(LAT_MAX)));

  p_windup_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (calc_en && ((clamp_hi && err_pos) || (clamp_lo && err_neg))) |=> $stable(m_q));
endmodule

bind ffd_duty_ctrl ffd_duty_ctrl_chk #(
  .DF(DF), .IW(IW), .LAT_MAX(SW + DF + 4)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .d_valid  (d_valid),
  .d_duty   (d_duty),
  .calc_en  (calc_en),
  .clamp_hi (clamp_hi),
  .clamp_lo (clamp_lo),
  .err_pos  (err_pos),
  .err_neg  (err_neg),
  .m_q      (m_q)
);

// File: tb/ffd_duty_ctrl_tb.sv
module ffd_duty_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IW_TB      = 18;
  localparam int LAT_LIM    = 16 + 16 + 3;
  localparam longint RMAX   = 2 * 65536;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic               rst;
  logic               s_valid;
  logic               s_ready;
  logic signed [15:0] s_vin, s_vref, s_vout;
  logic [15:0]        cfg_df;
  logic signed [15:0] cfg_kp, cfg_ki;
  logic [15:0]        cfg_thr;
  logic               d_valid;
  logic [15:0]        d_duty;

  ffd_duty_ctrl #(.IW(IW_TB)) u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_vin(s_vin), .s_vref(s_vref), .s_vout(s_vout),
    .cfg_df(cfg_df), .cfg_kp(cfg_kp), .cfg_ki(cfg_ki), .cfg_thr(cfg_thr),
    .d_valid(d_valid), .d_duty(d_duty)
  );

  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  int     sent   = 0;
  int     got    = 0;
  longint m_model = 0;
  longint exp_q[$];
  string  tag_q[$];
  int     acc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Reference model built from the requirement text.
  task automatic predict(input logic signed [15:0] vi, input logic signed [15:0] vr,
                         input logic signed [15:0] vo, output longint duty);
    longint ax, ar, q, ratio, e, mc, p, i, sum, mmax;
    bit hi, lo;
    ax = (vi < 0) ? -longint'(vi) : longint'(vi);
    ar = (vr < 0) ? -longint'(vr) : longint'(vr);
    if (ax == 0 || ax < longint'(cfg_thr)) ratio = RMAX;   // R4
    else begin                                              // R3
      q = (ar <<< 16) / ax;
      if (q > RMAX) q = RMAX;
      ratio = ((vi < 0) != (vr < 0)) ? -q : q;
    end
    e    = longint'(vr) - longint'(vo);
    mmax = (64'sd1 <<< (IW_TB - 1)) - 1;
    mc   = m_model + e;                                     // R6
    if (mc > mmax) mc = mmax;
    if (mc < -mmax - 1) mc = -mmax - 1;
    p   = (longint'(cfg_kp) * e) >>> 13;                    // R5
    i   = (longint'(cfg_ki) * mc) >>> 13;
    sum = longint'(cfg_df) + (ratio - longint'(cfg_df)) + p + i;  // R7
    lo  = sum < 0;
    hi  = sum > 65535;
    duty = lo ? 0 : (hi ? 65535 : sum);
    if (!((hi && e > 0) || (lo && e < 0))) m_model = mc;    // R8
  endtask

  // Driver: waits for ready, offers one sample, pushes the prediction.
  task automatic send(input int vi, input int vr, input int vo, input string tag, input bit junk);
    longint d;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_vin = 16'(vi); s_vref = 16'(vr); s_vout = 16'(vo);
    s_valid = 1'b1;
    predict(s_vin, s_vref, s_vout, d);
    exp_q.push_back(d);
    tag_q.push_back(tag);
    sent++;
    @(negedge clk);
    acc_q.push_back(cyc);
    s_valid = 1'b0;
    check(!s_ready, "R1 busy after accept", longint'(s_ready), 0);
    if (junk) begin
      for (int k = 0; k < 3; k++) begin
        s_vin = 16'sh7FFF; s_vref = -16'sh7FFF; s_vout = 16'sh7000;
        s_valid = 1'b1;
        @(negedge clk);
        check(!s_ready, "R1 offer while busy", longint'(s_ready), 0);
      end
      s_valid = 1'b0;
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: scoreboard compare on each result pulse.
  always @(negedge clk) begin
    if (!rst && d_valid) begin
      got++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected result", longint'(d_duty), -1);
      end else begin
        longint e;
        string  t;
        int     a;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = acc_q.pop_front();
        check(longint'(d_duty) == e, t, longint'(d_duty), e);
        check((cyc - a) <= LAT_LIM, "R2 latency", longint'(cyc - a), LAT_LIM);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst = 1'b1; s_valid = 1'b0;
    s_vin = '0; s_vref = '0; s_vout = '0;
    cfg_df = 16'hC000; cfg_kp = '0; cfg_ki = '0; cfg_thr = 16'h0400;
    repeat (3) @(negedge clk);
    check(d_duty == 16'd0 && !d_valid, "R9 reset outputs", longint'(d_duty), 0);
    check(s_ready, "R9 ready in reset", longint'(s_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check(d_duty == 16'd0 && s_ready, "R9 after reset", longint'(d_duty), 0);

    // R3 positive and negative half cycle, R7 clamps
    send(16'h4000, 16'h2000, 16'h2000, "R3 ratio half", 1'b0);
    send(-16'h4000, -16'h2000, -16'h2000, "R3 negative half", 1'b0);
    send(16'h2000, 16'h6000, 16'h6000, "R7 clamp high ratio limit", 1'b0);
    send(16'h4000, -16'h1000, -16'h1000, "R7 clamp low opposite signs", 1'b0);
    send(16'h7FFF, 16'h5A5A, 16'h5A5A, "R3 odd quotient", 1'b0);
    // R4 bypass below threshold and at zero
    send(16'h0100, 16'h0080, 16'h0080, "R4 below threshold", 1'b0);
    send(16'h0000, 16'h0000, 16'h0000, "R4 zero input", 1'b0);
    drain();

    // R5 proportional term
    cfg_kp = 16'sh4000; cfg_ki = '0; cfg_df = 16'h4000;
    send(16'h7FFF, 16'h3000, 16'h2000, "R5 positive error", 1'b0);
    send(16'h7FFF, 16'h3000, 16'h3800, "R5 negative error", 1'b0);
    drain();

    // R6 integral accumulation
    cfg_kp = '0; cfg_ki = 16'sh0400;
    send(16'h6000, 16'h2000, 16'h1000, "R6 integrate step 1", 1'b0);
    send(16'h6000, 16'h2000, 16'h1000, "R6 integrate step 2", 1'b0);
    send(16'h6000, 16'h2000, 16'h3000, "R6 integrate step 3", 1'b0);
    drain();

    // R6 integrator saturation
    cfg_kp = -16'sh0010; cfg_ki = '0;
    for (int k = 0; k < 4; k++)
      send(16'h7FFF, 16'h7FFF, -16'h8000, "R6 saturating fill", 1'b0);
    drain();
    cfg_kp = '0; cfg_ki = 16'sh0020;
    send(16'h4000, 16'h1000, 16'h1000, "R6 saturated integrator readout", 1'b0);
    drain();

    // R9 reset clears the integrator
    rst = 1'b1;
    m_model = 0;
    repeat (2) @(negedge clk);
    check(d_duty == 16'd0, "R9 mid-run reset duty", longint'(d_duty), 0);
    rst = 1'b0;
    send(16'h4000, 16'h1000, 16'h1000, "R9 integrator cleared", 1'b0);
    drain();

    // R8 anti-windup: clamped high with positive error, then reverse
    cfg_kp = '0; cfg_ki = 16'sh1000;
    for (int k = 0; k < 3; k++)
      send(16'h4000, 16'h4000, 16'h2000, "R8 clamped high", 1'b0);
    send(16'h4000, 16'h4000, 16'h6000, "R8 frozen integrator visible", 1'b0);
    drain();

    // R1 samples offered while busy are ignored
    cfg_ki = '0; cfg_df = 16'h8000;
    send(16'h6000, 16'h3000, 16'h3000, "R1 result with busy offers", 1'b1);
    send(16'h5000, 16'h2800, 16'h2800, "R1 next result unaffected", 1'b0);
    drain();
    check(got == sent, "R1 one result per accepted sample", got, sent);

    finish_run();
  end
endmodule